// File: doc/BRIEF.md
# Interrupt Report Scanner and Dispatcher

This block runs on the host side once an interrupt has been raised. Interrupt sources write their reports into a shared byte-addressed memory region rather than into registers. Each unit owns one byte in a source area and a 16-byte status record in a status area. When `start_i` pulses, the scanner goes through the units in a fixed order. It reads each unit's source byte and, if that byte is set, reads the one status byte it knows how to handle. It then emits a dispatch pulse that carries the unit index and the bit index. Every byte the scanner consumes is written back to zero, so a unit's next report can be seen.

Engine units come first. They are scanned in ascending index order, and only those enabled in the present mask are visited. After the engines, the primary controller unit is always checked. The secondary controller unit is checked only when it is marked present. A report byte is expected to read 0xFF when set. Any other nonzero value still counts as a report, but the block also raises an error pulse that carries the value and the byte address. All memory reads wait for a read-valid handshake, and each write completes in the cycle it is issued.

Top module: `irq_report_scanner`

## Requirements
- R1: A `start_i` pulse while idle raises `busy_o`. `busy_o` stays high until `done_o` pulses for exactly one cycle at the end of the scan. A `start_i` pulse while busy is ignored and produces no second `done_o`.
- R2: For each visited unit u, the byte at SRC_BASE+u is read. A nonzero value counts as received, and that same address is then written with 0x00. Every write the block issues carries data 0x00.
- R3: A unit's status byte, at STS_BASE + u*16 + bit, is read only after that unit's source byte was found nonzero. A unit whose source byte is zero has its status record left untouched.
- R4: For engine units only status bit ENG_BIT (default 0) is examined. For the two controller units only bit CTL_BIT (default 15) is examined. All other bytes of a status record are neither cleared nor dispatched.
- R5: A nonzero status byte produces one `disp_valid_o` pulse with `disp_unit_o` = u and `disp_bit_o` = the examined bit. The pulse comes in the same cycle as the write that clears that byte. A zero status byte produces no dispatch.
- R6: A consumed byte (source or status) that is nonzero but not 0xFF is still handled as received. It also gives an `err_valid_o` pulse, in the cycle of its clearing write, with `err_value_o` = the value read and `err_addr_o` = its address.
- R7: The scan visits engine units in ascending index order, then the primary controller (PRI_CTL_IDX, default 25), then the secondary controller (SEC_CTL_IDX, default 26) only if `sec_ctl_en_i` is 1. Mask bits at the two controller indices play no part in the engine pass.
- R8: An engine unit whose `unit_en_i` bit is 0 is not visited. Its source and status bytes stay unchanged.
- R9: A read waits for `mem_rvalid_i`, and the byte on `mem_rdata_i` is evaluated only in that cycle. No further memory access is issued while a read is outstanding.
- R10: After reset, `busy_o`, `done_o`, `mem_req_o`, `disp_valid_o` and `err_valid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a scan (ignored while busy) |
| unit_en_i | input | NUM_UNITS | Engine units present, sampled at start |
| sec_ctl_en_i | input | 1 | Secondary controller unit present, sampled at start |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | 8 | Write data (always 0x00) |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 8 | Read data byte |
| disp_valid_o | output | 1 | Dispatch pulse |
| disp_unit_o | output | log2(NUM_UNITS) | Unit index of the dispatch |
| disp_bit_o | output | log2(REC_BYTES) | Bit index of the dispatch |
| err_valid_o | output | 1 | Malformed value pulse |
| err_value_o | output | 8 | Malformed value read |
| err_addr_o | output | ADDR_W | Address of the malformed byte |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |

## Verification
The scanner is fed memory images with these patterns:
- An empty image shows that nothing fires spuriously.
- Sparse 0xFF engine reports check the ascending order and the clearing of bytes.
- A set source byte over an empty status record is separated from a set status byte under an empty source byte, which tests R3 from both sides.
- Odd values such as 0x01 and 0x80 check that error reporting is tied to the value read and that dispatch still happens.

Masked engines, engines above a controller index, and stray bytes in unexamined status slots check both the order and that nothing outside the scan is touched. The controllers are run with the secondary unit both present and absent. Read latencies of 1 to 4 cycles confirm that evaluation waits for the handshake.

// File: rtl/irq_scan_pkg.sv
package irq_scan_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PICK,
      ST_SRC_RD,
      ST_SRC_WAIT,
      ST_SRC_CLR,
      ST_STS_RD,
      ST_STS_WAIT,
      ST_STS_CLR,
      ST_DONE
   } scan_state_e;

   typedef enum logic [1:0] {
      PH_ENG,
      PH_PRI,
      PH_SEC,
      PH_END
   } scan_phase_e;

   localparam logic [7:0] BYTE_SET = 8'hFF;

endpackage

// File: rtl/irq_next_unit.sv
// Finds the lowest set mask bit at or above a cursor position.
module irq_next_unit #(
   parameter int N  = 64,
   parameter int CW = 7
) (
   input  logic [N-1:0]  mask_i,
   input  logic [CW-1:0] from_i,
   output logic          found_o,
   output logic [CW-1:0] idx_o
);

   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask_i[i] && (CW'(i) >= from_i)) begin
            found_o = 1'b1;
            idx_o   = CW'(i);
         end
      end
   end

endmodule

// File: rtl/irq_byte_judge.sv
// Classifies a report byte: received when nonzero, malformed when not the set pattern.
module irq_byte_judge
   import irq_scan_pkg::*;
(
   input  logic [7:0] byte_i,
   output logic       recv_o,
   output logic       bad_o
);

   assign recv_o = |byte_i;
   assign bad_o  = recv_o && (byte_i != BYTE_SET);

endmodule

// File: rtl/irq_addr_gen.sv
// Source and status byte addresses for a unit and bit slot.
module irq_addr_gen #(
   parameter int ADDR_W    = 12,
   parameter int UW        = 6,
   parameter int BW        = 4,
   parameter int SRC_BASE  = 1024,
   parameter int STS_BASE  = 0,
   parameter int REC_BYTES = 16
) (
   input  logic [UW-1:0]     unit_i,
   input  logic [BW-1:0]     bit_i,
   output logic [ADDR_W-1:0] src_addr_o,
   output logic [ADDR_W-1:0] sts_addr_o
);

   localparam bit REC_POW2 = (REC_BYTES & (REC_BYTES - 1)) == 0;

   logic [ADDR_W-1:0] rec_off;

   assign src_addr_o = ADDR_W'(SRC_BASE) + ADDR_W'(unit_i);

   generate
      if (REC_POW2) begin : g_shift
         assign rec_off = ADDR_W'(unit_i) << BW;
      end else begin : g_mult
         assign rec_off = ADDR_W'(unit_i) * ADDR_W'(REC_BYTES);
      end
   endgenerate

   assign sts_addr_o = ADDR_W'(STS_BASE) + rec_off + ADDR_W'(bit_i);

endmodule

// File: rtl/irq_report_scanner.sv
module irq_report_scanner
   import irq_scan_pkg::*;
#(
   parameter int NUM_UNITS   = 64,
   parameter int ADDR_W      = 12,
   parameter int SRC_BASE    = 1024,
   parameter int STS_BASE    = 0,
   parameter int REC_BYTES   = 16,
   parameter int PRI_CTL_IDX = 25,
   parameter int SEC_CTL_IDX = 26,
   parameter int ENG_BIT     = 0,
   parameter int CTL_BIT     = 15
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic [NUM_UNITS-1:0]          unit_en_i,
   input  logic                          sec_ctl_en_i,
   output logic                          mem_req_o,
   output logic                          mem_we_o,
   output logic [ADDR_W-1:0]             mem_addr_o,
   output logic [7:0]                    mem_wdata_o,
   input  logic                          mem_rvalid_i,
   input  logic [7:0]                    mem_rdata_i,
   output logic                          disp_valid_o,
   output logic [$clog2(NUM_UNITS)-1:0]  disp_unit_o,
   output logic [$clog2(REC_BYTES)-1:0]  disp_bit_o,
   output logic                          err_valid_o,
   output logic [7:0]                    err_value_o,
   output logic [ADDR_W-1:0]             err_addr_o,
   output logic                          busy_o,
   output logic                          done_o
);

   localparam int UW = $clog2(NUM_UNITS);
   localparam int BW = $clog2(REC_BYTES);
   localparam int CW = UW + 1;
   localparam logic [NUM_UNITS-1:0] CTL_MASK =
      (NUM_UNITS'(1) << PRI_CTL_IDX) | (NUM_UNITS'(1) << SEC_CTL_IDX);

   // elaboration-time parameter checks
   generate
      if (NUM_UNITS < 4) begin : g_bad_units
         $error("NUM_UNITS must be at least 4");
      end
      if (REC_BYTES < 2) begin : g_bad_rec
         $error("REC_BYTES must be at least 2");
      end
      if (PRI_CTL_IDX == SEC_CTL_IDX || PRI_CTL_IDX >= NUM_UNITS || SEC_CTL_IDX >= NUM_UNITS) begin : g_bad_ctl
         $error("controller indices must be distinct and below NUM_UNITS");
      end
      if (ENG_BIT >= REC_BYTES || CTL_BIT >= REC_BYTES) begin : g_bad_bit
         $error("dispatch bits must lie inside a status record");
      end
      if (SRC_BASE + NUM_UNITS > (1 << ADDR_W) || STS_BASE + NUM_UNITS * REC_BYTES > (1 << ADDR_W)) begin : g_bad_addr
         $error("report areas do not fit in the address space");
      end
   endgenerate

   scan_state_e          state_q;
   scan_phase_e          phase_q;
   logic [CW-1:0]        cursor_q;
   logic [UW-1:0]        unit_q;
   logic [BW-1:0]        bit_q;
   logic [NUM_UNITS-1:0] en_q;
   logic                 sec_q;
   logic [7:0]           byte_q;

   logic [NUM_UNITS-1:0] eng_mask;
   logic                 nxt_found;
   logic [CW-1:0]        nxt_idx;
   logic [ADDR_W-1:0]    src_addr, sts_addr;
   logic                 rd_recv, rd_bad_unused, held_recv_unused, held_bad;
   logic                 src_phase;

   assign eng_mask = en_q & ~CTL_MASK;

   irq_next_unit #(.N(NUM_UNITS), .CW(CW)) u_next (
      .mask_i  (eng_mask),
      .from_i  (cursor_q),
      .found_o (nxt_found),
      .idx_o   (nxt_idx)
   );

   irq_addr_gen #(
      .ADDR_W(ADDR_W), .UW(UW), .BW(BW), .SRC_BASE(SRC_BASE),
      .STS_BASE(STS_BASE), .REC_BYTES(REC_BYTES)
   ) u_addr (
      .unit_i     (unit_q),
      .bit_i      (bit_q),
      .src_addr_o (src_addr),
      .sts_addr_o (sts_addr)
   );

   irq_byte_judge u_judge_rd (
      .byte_i (mem_rdata_i),
      .recv_o (rd_recv),
      .bad_o  (rd_bad_unused)
   );

   irq_byte_judge u_judge_held (
      .byte_i (byte_q),
      .recv_o (held_recv_unused),
      .bad_o  (held_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         phase_q  <= PH_ENG;
         cursor_q <= '0;
         unit_q   <= '0;
         bit_q    <= '0;
         en_q     <= '0;
         sec_q    <= 1'b0;
         byte_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  en_q     <= unit_en_i;
                  sec_q    <= sec_ctl_en_i;
                  phase_q  <= PH_ENG;
                  cursor_q <= '0;
                  state_q  <= ST_PICK;
               end
            end
            ST_PICK: begin
               unique case (phase_q)
                  PH_ENG: begin
                     if (nxt_found) begin
                        unit_q   <= nxt_idx[UW-1:0];
                        bit_q    <= BW'(ENG_BIT);
                        cursor_q <= nxt_idx + CW'(1);
                        state_q  <= ST_SRC_RD;
                     end else begin
                        phase_q <= PH_PRI;
                     end
                  end
                  PH_PRI: begin
                     unit_q  <= UW'(PRI_CTL_IDX);
                     bit_q   <= BW'(CTL_BIT);
                     phase_q <= PH_SEC;
                     state_q <= ST_SRC_RD;
                  end
                  PH_SEC: begin
                     phase_q <= PH_END;
                     if (sec_q) begin
                        unit_q  <= UW'(SEC_CTL_IDX);
                        bit_q   <= BW'(CTL_BIT);
                        state_q <= ST_SRC_RD;
                     end
                  end
                  default: state_q <= ST_DONE;
               endcase
            end
            ST_SRC_RD: state_q <= ST_SRC_WAIT;
            ST_SRC_WAIT: begin
               if (mem_rvalid_i) begin
                  byte_q  <= mem_rdata_i;
                  state_q <= rd_recv ? ST_SRC_CLR : ST_PICK;
               end
            end
            ST_SRC_CLR: state_q <= ST_STS_RD;
            ST_STS_RD:  state_q <= ST_STS_WAIT;
            ST_STS_WAIT: begin
               if (mem_rvalid_i) begin
                  byte_q  <= mem_rdata_i;
                  state_q <= rd_recv ? ST_STS_CLR : ST_PICK;
               end
            end
            ST_STS_CLR: state_q <= ST_PICK;
            ST_DONE:    state_q <= ST_IDLE;
            default:    state_q <= ST_IDLE;
         endcase
      end
   end

   assign src_phase = (state_q == ST_SRC_RD) || (state_q == ST_SRC_WAIT) ||
                      (state_q == ST_SRC_CLR);

   assign mem_req_o   = (state_q == ST_SRC_RD) || (state_q == ST_STS_RD) ||
                        (state_q == ST_SRC_CLR) || (state_q == ST_STS_CLR);
   assign mem_we_o    = (state_q == ST_SRC_CLR) || (state_q == ST_STS_CLR);
   assign mem_addr_o  = src_phase ? src_addr : sts_addr;
   assign mem_wdata_o = 8'h00;

   assign disp_valid_o = (state_q == ST_STS_CLR);
   assign disp_unit_o  = unit_q;
   assign disp_bit_o   = bit_q;

   assign err_valid_o = mem_we_o && held_bad;
   assign err_value_o = byte_q;
   assign err_addr_o  = mem_addr_o;

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = (state_q == ST_DONE);

endmodule

// File: rtl/irq_report_scanner_chk.sv
module irq_report_scanner_chk #(
   parameter int NUM_UNITS   = 64,
   parameter int ADDR_W      = 12,
   parameter int REC_BYTES   = 16,
   parameter int PRI_CTL_IDX = 25,
   parameter int SEC_CTL_IDX = 26,
   parameter int ENG_BIT     = 0,
   parameter int CTL_BIT     = 15
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          start_i,
   input logic                          mem_req_o,
   input logic                          mem_we_o,
   input logic [ADDR_W-1:0]             mem_addr_o,
   input logic [7:0]                    mem_wdata_o,
   input logic                          mem_rvalid_i,
   input logic                          disp_valid_o,
   input logic [$clog2(NUM_UNITS)-1:0]  disp_unit_o,
   input logic [$clog2(REC_BYTES)-1:0]  disp_bit_o,
   input logic                          err_valid_o,
   input logic [7:0]                    err_value_o,
   input logic [ADDR_W-1:0]             err_addr_o,
   input logic                          busy_o,
   input logic                          done_o
);

   localparam int UW = $clog2(NUM_UNITS);
   localparam int BW = $clog2(REC_BYTES);

   logic [ADDR_W-1:0] last_rd_q;
   logic              rd_pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_rd_q <= '0;
         rd_pend_q <= 1'b0;
      end else begin
         if (mem_req_o && !mem_we_o) begin
            last_rd_q <= mem_addr_o;
            rd_pend_q <= 1'b1;
         end else if (mem_rvalid_i) begin
            rd_pend_q <= 1'b0;
         end
      end
   end

   // R2
   clear_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && mem_we_o |-> (mem_addr_o == last_rd_q) && (mem_wdata_o == 8'h00));

   // R9
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> !rd_pend_q);

   // R5
   disp_with_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid_o |-> mem_req_o && mem_we_o);

   // R4
   ctl_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid_o && ((disp_unit_o == UW'(PRI_CTL_IDX)) || (disp_unit_o == UW'(SEC_CTL_IDX)))
      |-> disp_bit_o == BW'(CTL_BIT));

   // R4
   eng_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid_o && (disp_unit_o != UW'(PRI_CTL_IDX)) && (disp_unit_o != UW'(SEC_CTL_IDX))
      |-> disp_bit_o == BW'(ENG_BIT));

   // R6
   err_with_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid_o |-> mem_req_o && mem_we_o && (err_addr_o == mem_addr_o) &&
                      (err_value_o != 8'h00) && (err_value_o != 8'hFF));

   // R1
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !busy_o);

   // R1
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !done_o && start_i |=> busy_o);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_o && !disp_valid_o && !err_valid_o && !done_o);

endmodule

bind irq_report_scanner irq_report_scanner_chk #(
   .NUM_UNITS(NUM_UNITS), .ADDR_W(ADDR_W), .REC_BYTES(REC_BYTES),
   .PRI_CTL_IDX(PRI_CTL_IDX), .SEC_CTL_IDX(SEC_CTL_IDX),
   .ENG_BIT(ENG_BIT), .CTL_BIT(CTL_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i),
   .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
   .mem_wdata_o(mem_wdata_o), .mem_rvalid_i(mem_rvalid_i),
   .disp_valid_o(disp_valid_o), .disp_unit_o(disp_unit_o), .disp_bit_o(disp_bit_o),
   .err_valid_o(err_valid_o), .err_value_o(err_value_o), .err_addr_o(err_addr_o),
   .busy_o(busy_o), .done_o(done_o)
);

// File: tb/irq_report_scanner_tb.sv
module irq_report_scanner_tb;

   localparam int NU   = 64;
   localparam int AW   = 12;
   localparam int SRC  = 1024;
   localparam int STS  = 0;
   localparam int PRI  = 25;
   localparam int SEC  = 26;
   localparam int EBIT = 0;
   localparam int CBIT = 15;
   localparam int MEMSZ = 4096;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [NU-1:0] unit_en = '0;
   logic          sec_en = 1'b0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic          mem_rvalid = 1'b0;
   logic [7:0]    mem_rdata = '0;
   logic          disp_valid;
   logic [5:0]    disp_unit;
   logic [3:0]    disp_bit;
   logic          err_valid;
   logic [7:0]    err_value;
   logic [AW-1:0] err_addr;
   logic          busy, done;

   logic [7:0] mem [0:MEMSZ-1];
   logic [7:0] img [0:MEMSZ-1];
   int disp_q[$];
   int err_q[$];
   int n_checks = 0;
   int n_fail = 0;
   int done_seen = 0;
   int lat = 1;
   int rd_cnt = 0;
   int rd_addr = 0;
   string cur_tag = "R10";

   always #5 clk = ~clk;

   irq_report_scanner #(
      .NUM_UNITS(NU), .ADDR_W(AW), .SRC_BASE(SRC), .STS_BASE(STS), .REC_BYTES(16),
      .PRI_CTL_IDX(PRI), .SEC_CTL_IDX(SEC), .ENG_BIT(EBIT), .CTL_BIT(CBIT)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .unit_en_i(unit_en),
      .sec_ctl_en_i(sec_en), .mem_req_o(mem_req), .mem_we_o(mem_we),
      .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rvalid_i(mem_rvalid),
      .mem_rdata_i(mem_rdata), .disp_valid_o(disp_valid), .disp_unit_o(disp_unit),
      .disp_bit_o(disp_bit), .err_valid_o(err_valid), .err_value_o(err_value),
      .err_addr_o(err_addr), .busy_o(busy), .done_o(done)
   );

   // memory model: writes land at the edge, reads answer after lat cycles
   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (mem_req && mem_we) mem[int'(mem_addr)] = mem_wdata;
      if (rd_cnt > 0) begin
         rd_cnt = rd_cnt - 1;
         if (rd_cnt == 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[rd_addr];
         end
      end
      if (mem_req && !mem_we) begin
         rd_addr = int'(mem_addr);
         rd_cnt  = lat;
      end
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", cur_tag, what, act, act, exp, exp);
      end
   endtask

   // monitor: pops expected items as the design produces results
   always @(negedge clk) begin
      if (done) done_seen++;
      if (disp_valid) begin
         if (disp_q.size() == 0) check(1'b0, "R5 unexpected dispatch unit*256+bit", int'(disp_unit) * 256 + int'(disp_bit), -1);
         else begin
            int e;
            e = disp_q.pop_front();
            check(e == int'(disp_unit) * 256 + int'(disp_bit), "R5 R7 dispatch unit*256+bit", int'(disp_unit) * 256 + int'(disp_bit), e);
         end
      end
      if (err_valid) begin
         if (err_q.size() == 0) check(1'b0, "R6 unexpected error value*65536+addr", int'(err_value) * 65536 + int'(err_addr), -1);
         else begin
            int e;
            e = err_q.pop_front();
            check(e == int'(err_value) * 65536 + int'(err_addr), "R6 error value*65536+addr", int'(err_value) * 65536 + int'(err_addr), e);
         end
      end
   end

   task automatic clear_mem();
      for (int i = 0; i < MEMSZ; i++) begin
         mem[i] = 8'h00;
         img[i] = 8'h00;
      end
   endtask

   task automatic put(input int addr, input logic [7:0] v);
      mem[addr] = v;
      img[addr] = v;
   endtask

   // expected behaviour from the requirements
   task automatic visit(input int u, input int b);
      int s, a, t;
      s = int'(img[SRC + u]);
      if (s != 0) begin
         if (s != 255) err_q.push_back(s * 65536 + SRC + u);
         img[SRC + u] = 8'h00;
         a = STS + u * 16 + b;
         t = int'(img[a]);
         if (t != 0) begin
            if (t != 255) err_q.push_back(t * 65536 + a);
            disp_q.push_back(u * 256 + b);
            img[a] = 8'h00;
         end
      end
   endtask

   task automatic run_scan(input logic [NU-1:0] en, input bit sec, input int l,
                           input bit restart, input string tag);
      int cyc;
      int d0;
      cur_tag = tag;
      lat = l;
      for (int u = 0; u < NU; u++)
         if (u != PRI && u != SEC && en[u]) visit(u, EBIT);
      visit(PRI, CBIT);
      if (sec) visit(SEC, CBIT);
      @(negedge clk);
      d0 = done_seen;
      unit_en = en;
      sec_en = sec;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      unit_en = '0;
      sec_en = ~sec;
      if (restart) begin
         repeat (3) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      cyc = 0;
      while (!done && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      check(cyc < 20000, "R1 scan finished (watchdog)", cyc, 0);
      repeat (4) @(negedge clk);
      check(done_seen - d0 == 1, "R1 done pulses per scan", done_seen - d0, 1);
      check(!busy, "R1 idle after done", int'(busy), 0);
      check(disp_q.size() == 0, "R5 missing dispatches", disp_q.size(), 0);
      check(err_q.size() == 0, "R6 missing errors", err_q.size(), 0);
      begin
         int bad;
         int first;
         bad = 0;
         first = -1;
         for (int i = 0; i < MEMSZ; i++)
            if (mem[i] !== img[i]) begin
               bad++;
               if (first < 0) first = i;
            end
         check(bad == 0, "R2 R3 R4 R8 memory image mismatches (first addr in log)", first, -1);
      end
      disp_q.delete();
      err_q.delete();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      logic [NU-1:0] all_en;
      all_en = '1;
      clear_mem();
      repeat (3) @(negedge clk);
      // R10 reset state
      cur_tag = "R10";
      check(!busy && !done && !mem_req && !disp_valid && !err_valid, "R10 outputs in reset",
            int'({busy, done, mem_req, disp_valid, err_valid}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(!busy && !done && !mem_req && !disp_valid && !err_valid, "R10 outputs after reset",
            int'({busy, done, mem_req, disp_valid, err_valid}), 0);

      // empty image: nothing fires
      run_scan(all_en, 1'b1, 1, 1'b0, "R2");

      // sparse engine reports, ascending order
      clear_mem();
      put(SRC + 3, 8'hFF);  put(STS + 3 * 16, 8'hFF);
      put(SRC + 40, 8'hFF); put(STS + 40 * 16, 8'hFF);
      put(SRC + 10, 8'hFF); put(STS + 10 * 16, 8'hFF);
      run_scan(all_en, 1'b0, 2, 1'b0, "R5");

      // source set over empty status, and status set under empty source
      clear_mem();
      put(SRC + 5, 8'hFF);
      put(SRC + 7, 8'h00); put(STS + 7 * 16, 8'hFF);
      run_scan(all_en, 1'b0, 1, 1'b0, "R3");

      // malformed values still received, reported
      clear_mem();
      put(SRC + 12, 8'h01); put(STS + 12 * 16, 8'h80);
      put(SRC + 13, 8'hFF); put(STS + 13 * 16, 8'h7E);
      run_scan(all_en, 1'b1, 3, 1'b0, "R6");

      // order and mask: engine 40 before primary 25, masked 50 untouched
      clear_mem();
      put(SRC + 2, 8'hFF);   put(STS + 2 * 16, 8'hFF); put(STS + 2 * 16 + 3, 8'hFF);
      put(SRC + 40, 8'hFF);  put(STS + 40 * 16, 8'hFF);
      put(SRC + 50, 8'hFF);  put(STS + 50 * 16, 8'hFF);
      put(SRC + PRI, 8'hFF); put(STS + PRI * 16 + CBIT, 8'hFF);
      put(SRC + SEC, 8'hFF); put(STS + SEC * 16 + CBIT, 8'hFF);
      run_scan((NU'(1) << 2) | (NU'(1) << 40) | (NU'(1) << PRI), 1'b0, 1, 1'b0, "R7");
      clear_mem();
      put(SRC + 50, 8'hFF); put(STS + 50 * 16, 8'hFF);
      run_scan(~(NU'(1) << 50), 1'b0, 2, 1'b0, "R8");

      // controllers: only the controller bit, secondary present
      clear_mem();
      put(SRC + PRI, 8'hFF); put(STS + PRI * 16 + CBIT, 8'hFF); put(STS + PRI * 16, 8'hFF);
      put(SRC + SEC, 8'hFF); put(STS + SEC * 16 + CBIT, 8'h02); put(STS + SEC * 16, 8'hFF);
      put(SRC + 0, 8'hFF);   put(STS + 0 * 16 + CBIT, 8'hFF);
      run_scan(all_en, 1'b1, 1, 1'b0, "R4");

      // start while busy ignored
      clear_mem();
      put(SRC + 1, 8'hFF);  put(STS + 1 * 16, 8'hFF);
      put(SRC + 63, 8'hFF); put(STS + 63 * 16, 8'hFF);
      run_scan(all_en, 1'b1, 2, 1'b1, "R1");

      // long read latency
      clear_mem();
      put(SRC + 4, 8'hFF);   put(STS + 4 * 16, 8'hFF);
      put(SRC + 30, 8'h40);  put(STS + 30 * 16, 8'hFF);
      put(SRC + PRI, 8'hFF); put(STS + PRI * 16 + CBIT, 8'hFF);
      run_scan(all_en, 1'b1, 4, 1'b0, "R9");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule